// File: doc/BRIEF.md
# Conversion Sequencer with Chop Control

This block runs the conversions of one analog front-end channel. A set of digital result channels can be assigned to that front end. When a trigger arrives, the sequencer drives the input-multiplexer selection of the lowest-numbered assigned channel. It then waits for the anti-alias filter to settle, but only if the filter is in the path and the selection actually changed. After that it pulses a start request to the decimator, which initializes the modulator and runs the conversion. When the decimator reports completion, the sequencer moves to the next assigned channel. After the last one it either stops (incremental mode) or wraps around (continuous mode).

The block also drives the amplifier chopping enable and a chop clock. The chop clock is divided from the modulator clock by a power of two between 2 and 256. The analog circuits and the decimator datapath sit outside the block and are reached only through the start/done handshake and the selection outputs.

Top module: `conv_sequencer`

## Requirements
- R1: After reset, busy, dec_start, chop_en and overrun are 0, and mux_sel and active_ch are 0.
- R2: A trigger seen while idle with a non-zero assign_mask latches the mask. In the next cycle busy is 1, active_ch is the lowest set mask index i, and mux_sel equals chan_sel_map bits [i*SEL_W +: SEL_W]. mux_sel changes only on an accepted trigger or on a completed conversion.
- R3: dec_start is a single-cycle pulse, issued only while busy and after any settling wait. The sequencer then waits for dec_done before it changes channel.
- R4: When a new selection differs from the current mux_sel, aaf_bypass is 0 and settle_cycles is N>0, dec_start rises exactly N cycles later than it would without the wait. No dec_start is issued during the wait.
- R5: There is no settling wait when aaf_bypass is 1, when settle_cycles is 0, or when the new selection equals the current mux_sel.
- R6: On dec_done the next channel is the lowest set bit of the latched mask above the current index. A mask change while busy has no effect on the running sequence.
- R7: In incremental mode (cont_mode 0), dec_done for the highest assigned channel returns the block to idle (busy 0).
- R8: In continuous mode (cont_mode 1), the channel after the highest assigned one is the lowest assigned one. Clearing cont_mode lets the sequence stop after its highest channel.
- R9: A trigger while busy does not change the channel or the selection, and sets overrun. overrun stays set until the next accepted trigger clears it. A trigger with an all-zero mask is ignored.
- R10: chop_en equals chop_on while busy and is 0 while idle.
- R11: chop_clk toggles freely with a period of 2^(code+1) clock cycles. code is the chop_div value captured at the last accepted trigger; after reset it is 4, giving a period of 32. A chop_div change while busy has no effect until the next accepted trigger.
- R12: dec_done while idle has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Modulator clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| trig | input | 1 | Conversion trigger |
| cont_mode | input | 1 | 1 = continuous, 0 = incremental |
| assign_mask | input | NUM_CH | Digital channels served by this front end |
| chan_sel_map | input | NUM_CH*SEL_W | Input selection for each digital channel, channel i at [i*SEL_W +: SEL_W] |
| settle_cycles | input | SETTLE_W | Filter settling wait in cycles |
| aaf_bypass | input | 1 | 1 = filter bypassed, no wait |
| chop_on | input | 1 | Chopping requested for conversions |
| chop_div | input | CODE_W | Chop divider code, period 2^(code+1) |
| dec_done | input | 1 | Decimator reports end of conversion |
| mux_sel | output | SEL_W | Current input-multiplexer selection |
| active_ch | output | IDX_W | Digital channel being converted |
| dec_start | output | 1 | Start pulse to the decimator |
| busy | output | 1 | A sequence is in progress |
| chop_en | output | 1 | Amplifier chopping enable |
| chop_clk | output | 1 | Divided chop clock |
| overrun | output | 1 | Trigger arrived while busy |

## Verification
The properties take dec_done to be a short pulse that the decimator returns only after a start request. They also take trig to be a plain level sampled on the clock, with no assumption about how often it comes. The selection-hold property relies on chan_sel_map changing the output only through an accepted trigger or a completed conversion, so the stimulus changes configuration freely while the block is busy to show that such changes are not picked up. The stimulus raises dec_done only once the block has left the start cycle. The single deliberate exception is the idle-time pulse that R12 calls for.

// File: rtl/seq_pkg.sv
package seq_pkg;

  typedef enum logic [1:0] {
    SQ_IDLE   = 2'd0,
    SQ_SETTLE = 2'd1,
    SQ_START  = 2'd2,
    SQ_WAIT   = 2'd3
  } sq_state_e;

  // chop divider code after reset: period 2^(4+1) = 32 modulator cycles
  localparam int CHOP_RST_CODE = 4;

  function automatic int chop_period(input int code);
    return 1 << (code + 1);
  endfunction

endpackage

// File: rtl/seq_chan_pick.sv
module seq_chan_pick #(
  parameter int NUM_CH = 4,
  parameter int IDX_W  = 2
) (
  input  logic [NUM_CH-1:0] mask,
  input  logic [IDX_W-1:0]  cur_idx,
  output logic [IDX_W-1:0]  first_idx,
  output logic [IDX_W-1:0]  next_idx,
  output logic              has_next
);

  function automatic logic [IDX_W-1:0] lowest_set(input logic [NUM_CH-1:0] m);
    logic [IDX_W-1:0] r;
    r = '0;
    for (int i = NUM_CH - 1; i >= 0; i--)
      if (m[i]) r = IDX_W'(i);
    return r;
  endfunction

  function automatic logic [NUM_CH-1:0] above_only(input logic [NUM_CH-1:0] m,
                                                   input logic [IDX_W-1:0] idx);
    logic [NUM_CH-1:0] r;
    for (int i = 0; i < NUM_CH; i++)
      r[i] = m[i] && (i > int'(idx));
    return r;
  endfunction

  logic [NUM_CH-1:0] upper;

  always_comb begin
    upper     = above_only(mask, cur_idx);
    first_idx = lowest_set(mask);
    next_idx  = lowest_set(upper);
    has_next  = |upper;
  end

endmodule

// File: rtl/seq_settle_timer.sv
module seq_settle_timer #(
  parameter int CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             run,
  output logic             last
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      cnt_q <= '0;
    else if (load)
      cnt_q <= load_val;
    else if (run && cnt_q != '0)
      cnt_q <= cnt_q - CNT_W'(1);
  end

  assign last = run && (cnt_q == CNT_W'(1));

endmodule

// File: rtl/seq_chop_gen.sv
module seq_chop_gen #(
  parameter int STAGES   = 8,
  parameter int CODE_W   = 3,
  parameter int RST_CODE = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              capture,
  input  logic [CODE_W-1:0] code_in,
  output logic              chop_clk
);

  logic [STAGES-1:0] div_q;
  logic [CODE_W-1:0] code_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q  <= '0;
      code_q <= CODE_W'(RST_CODE);
    end else begin
      div_q <= div_q + STAGES'(1);
      if (capture) code_q <= code_in;
    end
  end

  // bit k of a free-running counter has period 2^(k+1)
  assign chop_clk = div_q[code_q];

endmodule

// File: rtl/conv_sequencer.sv
module conv_sequencer
  import seq_pkg::*;
#(
  parameter int NUM_CH      = 4,
  parameter int SEL_W       = 4,
  parameter int SETTLE_W    = 12,
  parameter int CHOP_STAGES = 8,
  localparam int IDX_W      = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
  localparam int CODE_W     = $clog2(CHOP_STAGES)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    trig,
  input  logic                    cont_mode,
  input  logic [NUM_CH-1:0]       assign_mask,
  input  logic [NUM_CH*SEL_W-1:0] chan_sel_map,
  input  logic [SETTLE_W-1:0]     settle_cycles,
  input  logic                    aaf_bypass,
  input  logic                    chop_on,
  input  logic [CODE_W-1:0]       chop_div,
  input  logic                    dec_done,
  output logic [SEL_W-1:0]        mux_sel,
  output logic [IDX_W-1:0]        active_ch,
  output logic                    dec_start,
  output logic                    busy,
  output logic                    chop_en,
  output logic                    chop_clk,
  output logic                    overrun
);

  function automatic logic [SEL_W-1:0] sel_of(input logic [NUM_CH*SEL_W-1:0] map,
                                              input logic [IDX_W-1:0] idx);
    return map[int'(idx)*SEL_W +: SEL_W];
  endfunction

  sq_state_e         state_q, state_d;
  logic [NUM_CH-1:0] mask_q;
  logic [IDX_W-1:0]  idx_q;
  logic [SEL_W-1:0]  sel_q;
  logic              overrun_q;

  // named internal events
  logic              accept_w;
  logic              done_w;
  logic              advance_w;
  logic              settle_w;
  logic              settle_last_w;
  logic              need_settle_w;
  logic [NUM_CH-1:0] pick_mask;
  logic [IDX_W-1:0]  first_idx, next_idx, target_idx;
  logic              has_next;
  logic [SEL_W-1:0]  target_sel;

  assign busy      = (state_q != SQ_IDLE);
  assign accept_w  = (state_q == SQ_IDLE) && trig && (|assign_mask);
  assign done_w    = (state_q == SQ_WAIT) && dec_done;
  assign settle_w  = (state_q == SQ_SETTLE);
  assign pick_mask = (state_q == SQ_IDLE) ? assign_mask : mask_q;

  seq_chan_pick #(.NUM_CH(NUM_CH), .IDX_W(IDX_W)) u_pick (
    .mask      (pick_mask),
    .cur_idx   (idx_q),
    .first_idx (first_idx),
    .next_idx  (next_idx),
    .has_next  (has_next)
  );

  always_comb begin
    target_idx    = (done_w && has_next) ? next_idx : first_idx;
    target_sel    = sel_of(chan_sel_map, target_idx);
    advance_w     = accept_w || (done_w && (has_next || cont_mode));
    need_settle_w = !aaf_bypass && (settle_cycles != '0) && (target_sel != sel_q);
  end

  seq_settle_timer #(.CNT_W(SETTLE_W)) u_settle (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (advance_w && need_settle_w),
    .load_val (settle_cycles),
    .run      (settle_w),
    .last     (settle_last_w)
  );

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      SQ_IDLE:   if (advance_w) state_d = need_settle_w ? SQ_SETTLE : SQ_START;
      SQ_SETTLE: if (settle_last_w) state_d = SQ_START;
      SQ_START:  state_d = SQ_WAIT;
      SQ_WAIT: begin
        if (advance_w)   state_d = need_settle_w ? SQ_SETTLE : SQ_START;
        else if (done_w) state_d = SQ_IDLE;
      end
      default:   state_d = SQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= SQ_IDLE;
      mask_q    <= '0;
      idx_q     <= '0;
      sel_q     <= '0;
      overrun_q <= 1'b0;
    end else begin
      state_q <= state_d;
      if (advance_w) begin
        idx_q <= target_idx;
        sel_q <= target_sel;
      end
      if (accept_w) begin
        mask_q    <= assign_mask;
        overrun_q <= 1'b0;
      end else if (busy && trig) begin
        overrun_q <= 1'b1;
      end
    end
  end

  seq_chop_gen #(
    .STAGES   (CHOP_STAGES),
    .CODE_W   (CODE_W),
    .RST_CODE (CHOP_RST_CODE)
  ) u_chop (
    .clk      (clk),
    .rst_n    (rst_n),
    .capture  (accept_w),
    .code_in  (chop_div),
    .chop_clk (chop_clk)
  );

  assign mux_sel   = sel_q;
  assign active_ch = idx_q;
  assign dec_start = (state_q == SQ_START);
  assign chop_en   = busy && chop_on;
  assign overrun   = overrun_q;

endmodule

// File: rtl/conv_sequencer_chk.sv
module conv_sequencer_chk #(
  parameter int SEL_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             trig,
  input logic             dec_done,
  input logic             dec_start,
  input logic             busy,
  input logic             overrun,
  input logic             chop_en,
  input logic [SEL_W-1:0] mux_sel,
  input logic             accept_w,
  input logic             settle_w
);

  p_start_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
    dec_start |=> !dec_start);

  p_start_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
    dec_start |-> busy);

  p_no_start_settle_r4: assert property (@(posedge clk) disable iff (!rst_n)
    settle_w |-> !dec_start);

  p_sel_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(accept_w || dec_done) |=> $stable(mux_sel));

  p_busy_trig_overrun_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && trig) |=> overrun);

  p_accept_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    accept_w |=> (busy && !overrun));

  p_chop_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !chop_en);

endmodule

bind conv_sequencer conv_sequencer_chk #(.SEL_W(SEL_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .trig      (trig),
  .dec_done  (dec_done),
  .dec_start (dec_start),
  .busy      (busy),
  .overrun   (overrun),
  .chop_en   (chop_en),
  .mux_sel   (mux_sel),
  .accept_w  (accept_w),
  .settle_w  (settle_w)
);

// File: tb/conv_sequencer_tb.sv
module conv_sequencer_tb;

  localparam int NUM_CH = 4;
  localparam int SEL_W  = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        trig = 1'b0, cont_mode = 1'b0, aaf_bypass = 1'b1, chop_on = 1'b0, dec_done = 1'b0;
  logic [3:0]  assign_mask = '0;
  logic [15:0] chan_sel_map = '0;
  logic [11:0] settle_cycles = '0;
  logic [2:0]  chop_div = 3'd0;
  logic [3:0]  mux_sel;
  logic [1:0]  active_ch;
  logic        dec_start, busy, chop_en, chop_clk, overrun;

  int checks = 0;
  int errors = 0;
  bit done_flag = 1'b0;

  conv_sequencer #(.NUM_CH(NUM_CH), .SEL_W(SEL_W), .SETTLE_W(12), .CHOP_STAGES(8)) u_dut (
    .clk(clk), .rst_n(rst_n), .trig(trig), .cont_mode(cont_mode),
    .assign_mask(assign_mask), .chan_sel_map(chan_sel_map),
    .settle_cycles(settle_cycles), .aaf_bypass(aaf_bypass), .chop_on(chop_on),
    .chop_div(chop_div), .dec_done(dec_done), .mux_sel(mux_sel),
    .active_ch(active_ch), .dec_start(dec_start), .busy(busy),
    .chop_en(chop_en), .chop_clk(chop_clk), .overrun(overrun)
  );

  always #5 clk = ~clk;

  task automatic check(input int act, input int exp, input string req);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic pulse_trig();
    @(negedge clk); trig = 1'b1;
    @(negedge clk); trig = 1'b0;
  endtask

  task automatic give_done();
    @(negedge clk); dec_done = 1'b1;
    @(negedge clk); dec_done = 1'b0;
  endtask

  // counts extra cycles until dec_start, then checks channel and selection
  task automatic wait_start(input int exp_wait, input int exp_ch, input int exp_sel,
                            input string req);
    int n = 0;
    while (!dec_start && n < 400) begin
      @(negedge clk); n++;
    end
    check(n, exp_wait, {req, " start delay"});
    check(int'(active_ch), exp_ch, {req, " active_ch"});
    check(int'(mux_sel), exp_sel, {req, " mux_sel"});
    check(int'(busy), 1, {req, " busy"});
  endtask

  task automatic measure_period(output int per);
    logic prev;
    int n = 0;
    prev = chop_clk;
    forever begin
      @(negedge clk);
      if (!prev && chop_clk) break;
      prev = chop_clk;
    end
    prev = chop_clk;
    forever begin
      @(negedge clk); n++;
      if (!prev && chop_clk) break;
      prev = chop_clk;
    end
    per = n;
  endtask

  task automatic t_reset();
    check(int'(busy), 0, "R1 busy");
    check(int'(dec_start), 0, "R1 dec_start");
    check(int'(chop_en), 0, "R1 chop_en");
    check(int'(overrun), 0, "R1 overrun");
    check(int'(mux_sel), 0, "R1 mux_sel");
    check(int'(active_ch), 0, "R1 active_ch");
  endtask

  task automatic t_chop_default();
    int per;
    measure_period(per);
    check(per, 32, "R11 default chop period");
  endtask

  task automatic t_incremental();
    aaf_bypass = 1'b1; cont_mode = 1'b0;
    chan_sel_map = {4'd9, 4'd0, 4'd5, 4'd0};
    assign_mask = 4'b1010;
    pulse_trig();
    wait_start(0, 1, 5, "R2");
    give_done();
    wait_start(0, 3, 9, "R6");
    give_done();
    check(int'(busy), 0, "R7 idle after last channel");
  endtask

  task automatic t_settle();
    aaf_bypass = 1'b0; settle_cycles = 12'd5;
    chan_sel_map = {4'd0, 4'd7, 4'd0, 4'd2};
    assign_mask = 4'b0101;
    pulse_trig();
    wait_start(5, 0, 2, "R4 first");
    give_done();
    wait_start(5, 2, 7, "R4 switch");
    give_done();
    check(int'(busy), 0, "R7 settle run idle");
    aaf_bypass = 1'b1;
    pulse_trig();
    wait_start(0, 0, 2, "R5 bypass");
    give_done();
    wait_start(0, 2, 7, "R5 bypass");
    give_done();
    aaf_bypass = 1'b0;
    chan_sel_map = {4'd0, 4'd7, 4'd0, 4'd7};
    assign_mask = 4'b0001;
    pulse_trig();
    wait_start(0, 0, 7, "R5 same selection");
    give_done();
    settle_cycles = 12'd0;
    chan_sel_map = {4'd0, 4'd7, 4'd0, 4'd3};
    pulse_trig();
    wait_start(0, 0, 3, "R5 zero count");
    give_done();
    check(int'(busy), 0, "R7 idle");
  endtask

  task automatic t_continuous();
    aaf_bypass = 1'b1; cont_mode = 1'b1;
    chan_sel_map = {4'd0, 4'd6, 4'd4, 4'd0};
    assign_mask = 4'b0110;
    pulse_trig();
    wait_start(0, 1, 4, "R8 first");
    give_done();
    wait_start(0, 2, 6, "R8 second");
    give_done();
    wait_start(0, 1, 4, "R8 wrap");
    give_done();
    wait_start(0, 2, 6, "R8 second pass");
    cont_mode = 1'b0;
    give_done();
    check(int'(busy), 0, "R8 stop after clearing cont_mode");
  endtask

  task automatic t_overrun();
    aaf_bypass = 1'b1;
    chan_sel_map = {4'd0, 4'd0, 4'd3, 4'd1};
    assign_mask = 4'b0011;
    pulse_trig();
    wait_start(0, 0, 1, "R9 base");
    assign_mask = 4'b1100;
    pulse_trig();
    check(int'(overrun), 1, "R9 overrun set");
    check(int'(active_ch), 0, "R9 busy trigger ignored ch");
    check(int'(mux_sel), 1, "R9 busy trigger ignored sel");
    give_done();
    wait_start(0, 1, 3, "R6 latched mask");
    give_done();
    check(int'(busy), 0, "R7 idle");
    check(int'(overrun), 1, "R9 overrun sticky");
    assign_mask = 4'b0000;
    pulse_trig();
    check(int'(busy), 0, "R9 zero mask ignored");
    check(int'(overrun), 1, "R9 zero mask keeps flag");
    assign_mask = 4'b0001;
    pulse_trig();
    check(int'(overrun), 0, "R9 accept clears");
    wait_start(0, 0, 1, "R9 after clear");
    give_done();
  endtask

  task automatic t_chop();
    int per;
    aaf_bypass = 1'b1; chop_on = 1'b1;
    check(int'(chop_en), 0, "R10 idle chop_en");
    chop_div = 3'd0;
    assign_mask = 4'b0001;
    pulse_trig();
    wait_start(0, 0, 1, "R10 start");
    chop_div = 3'd6;
    measure_period(per);
    check(per, 2, "R11 captured code 0");
    check(int'(chop_en), 1, "R10 chop_en busy");
    chop_on = 1'b0;
    @(negedge clk);
    check(int'(chop_en), 0, "R10 chop_on low");
    chop_on = 1'b1;
    give_done();
    check(int'(chop_en), 0, "R10 chop_en idle");
    pulse_trig();
    wait_start(0, 0, 1, "R11 start");
    measure_period(per);
    check(per, 128, "R11 captured code 6");
    give_done();
  endtask

  task automatic t_idle_done();
    dec_done = 1'b1;
    @(negedge clk);
    @(negedge clk);
    dec_done = 1'b0;
    check(int'(busy), 0, "R12 idle done ignored busy");
    check(int'(dec_start), 0, "R12 idle done ignored start");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done_flag) begin
      checks++; errors++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_chop_default();
    t_incremental();
    t_settle();
    t_continuous();
    t_overrun();
    t_chop();
    t_idle_done();
    done_flag = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule